// File: doc/BRIEF.md
# Stack and Program-Flow Control Unit

This block executes the stack and control-transfer instruction group of a 16-bit processor, the group whose upper byte is 0x0F. It holds the program counter, the stack pointer and the interrupt-return register. Each cycle it looks at the current instruction word. It produces the next program counter, the stack memory address and write strobe, and the register-file writeback request for that word.

The register file, the stack memory and interrupt entry detection sit outside the block. The surrounding logic supplies four values each cycle: the contents of the register named in bits 3:0, the contents of r15, the status register, and the stack memory read data for the address the block presents. The interrupt-entry logic loads the interrupt-return register through a load strobe. A stall input freezes all architectural state and suppresses every strobe.

Top module: `stack_flow_unit`

## Requirements
- R1: While rst_n is low at a clock edge, pc, sp and the interrupt-return register are cleared to 0. After reset, stack_we, wb_en and zero_we stay low until an instruction asks for them.
- R2: PUSH (word 0x0F0r) drives stack_addr = sp, stack_wdata = reg_val and stack_we = 1 in the same cycle. At the next edge, sp becomes sp+1.
- R3: POP (word 0x0F1r) drives stack_addr = sp-1 and a writeback of stack_rdata into register r. It raises zero_we with zero_val = (stack_rdata == 0). At the next edge, sp becomes sp-1.
- R4: FSR (word 0x0FCr) requests a writeback of status_in into register r.
- R5: JMP (word 0x0FDr) loads pc from reg_val.
- R6: CALL (word 0x0FEr) requests a writeback of pc+1 into register 15 and loads pc from reg_val.
- R7: RET is only the exact word 0x0FFF, and it loads pc from r15_val. The words 0x0FF0 to 0x0FFE act as no-operations.
- R8: RETI is only the exact word 0x0FBF, and it loads pc from the interrupt-return register. A cycle with iret_load high stores iret_addr, and the stored value is first used by a RETI in a later cycle.
- R9: Every other word, whether in the 0x0F group (sub-codes 0x2 to 0xA, or 0xB and 0xF with a register field other than 0xF) or outside it, advances pc by one and changes no other state or output strobe.
- R10: While stall is high, pc and sp hold, and stack_we, wb_en and zero_we are low.
- R11: sp wraps modulo 2^16. A POP at sp = 0 addresses 0xFFFF and leaves sp = 0xFFFF, and a PUSH at 0xFFFF leaves sp = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze state and suppress strobes |
| instr | input | 16 | Current instruction word |
| reg_val | input | 16 | Contents of the register named in instr[3:0] |
| r15_val | input | 16 | Contents of register 15 |
| status_in | input | 16 | Status register value |
| stack_rdata | input | 16 | Stack memory read data at stack_addr |
| iret_load | input | 1 | Load the interrupt-return register |
| iret_addr | input | 16 | Value to load |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| stack_addr | output | 16 | Stack memory address |
| stack_we | output | 1 | Stack memory write strobe |
| stack_wdata | output | 16 | Stack memory write data |
| wb_en | output | 1 | Register writeback request |
| wb_idx | output | 4 | Writeback register index |
| wb_data | output | 16 | Writeback data |
| zero_we | output | 1 | Zero-flag update strobe |
| zero_val | output | 1 | New zero-flag value |

## Verification
The assertions check on every cycle that the stack pointer moves by exactly one in the right direction on a push or pop, and that a stall holds pc and sp. They also check that the stack write address equals sp, that a CALL link goes to register 15 with pc+1, and that a stack write and a zero-flag update never occur together.

Only the bench's scenarios can show the rest:
- the decode of the exact RET and RETI words against their near neighbours;
- the targets taken from the register, r15 and interrupt-return paths;
- the one-cycle latency of an interrupt-return load;
- the wrap of sp at 0 and at 0xFFFF.

The bench covers these by sweeping every 16-bit instruction word against an arithmetic model.

// File: rtl/sfu_pkg.sv
// Package: shared widths and the operation type for the stack/flow unit.
// Assumes a 16-bit word with an 8-bit group code and a 4-bit register field.
package sfu_pkg;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_RETI,
        OP_FSR,
        OP_JMP,
        OP_CALL,
        OP_RET
    } sfu_op_e;
endpackage

// File: rtl/sfu_decode.sv
// Module: sfu_decode
// Maps one instruction word to a flow/stack operation. Words outside the
// group, and group encodings that are not listed, map to OP_NONE.
// Assumes the group code occupies the upper byte and the sub-code bits 7:4.
module sfu_decode
    import sfu_pkg::*;
#(
    parameter int          W          = 16,
    parameter logic [7:0]  GROUP_CODE = 8'h0F
) (
    input  logic [W-1:0] instr,
    output sfu_op_e      op
);
    localparam int SUB_LO = 4;

    logic       in_group;
    logic [3:0] sub;
    logic [3:0] ridx;

    assign in_group = (instr[W-1:W-8] == GROUP_CODE);
    assign sub      = instr[SUB_LO+3:SUB_LO];
    assign ridx     = instr[3:0];

    // Purpose: select the operation from the sub-code and exact-word matches.
    always_comb begin
        op = OP_NONE;
        if (in_group) begin
            unique case (sub)
                4'h0:    op = OP_PUSH;
                4'h1:    op = OP_POP;
                4'hB:    op = (ridx == 4'hF) ? OP_RETI : OP_NONE;
                4'hC:    op = OP_FSR;
                4'hD:    op = OP_JMP;
                4'hE:    op = OP_CALL;
                4'hF:    op = (ridx == 4'hF) ? OP_RET : OP_NONE;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sfu_pc_ctrl.sv
// Module: sfu_pc_ctrl
// Owns the program counter and the interrupt-return register. It picks the
// next pc from the register operand, r15, the interrupt-return register or
// pc+1. Assumes the caller gates all updates with 'advance'; the
// interrupt-return register loads independently of stall.
module sfu_pc_ctrl
    import sfu_pkg::*;
#(
    parameter int          W        = 16,
    parameter logic [W-1:0] RESET_PC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  sfu_op_e      op,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] r15_val,
    input  logic         iret_load,
    input  logic [W-1:0] iret_addr,
    output logic [W-1:0] pc,
    output logic [W-1:0] pc_inc
);
    logic [W-1:0] iret_q;
    logic [W-1:0] pc_next;

    assign pc_inc = pc + W'(1);

    // Purpose: choose the next program counter for the decoded operation.
    always_comb begin
        unique case (op)
            OP_JMP,
            OP_CALL: pc_next = reg_val;
            OP_RET:  pc_next = r15_val;
            OP_RETI: pc_next = iret_q;
            default: pc_next = pc_inc;
        endcase
    end

    // Purpose: program counter register, held while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= RESET_PC;
        else if (advance) pc <= pc_next;
    end

    // Purpose: interrupt-return register, loaded by the interrupt-entry logic.
    always_ff @(posedge clk) begin
        if (!rst_n)         iret_q <= '0;
        else if (iret_load) iret_q <= iret_addr;
    end
endmodule

// File: rtl/sfu_stack_ctrl.sv
// Module: sfu_stack_ctrl
// Owns the stack pointer. A push writes at sp, then increments it. A pop
// reads at sp-1, then leaves sp there. Arithmetic wraps modulo 2^W.
// Assumes stack memory reads combinationally at the presented address.
module sfu_stack_ctrl
    import sfu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  sfu_op_e      op,
    output logic [W-1:0] sp,
    output logic [W-1:0] addr,
    output logic         we
);
    logic [W-1:0] sp_up;
    logic [W-1:0] sp_dn;

    assign sp_up = sp + W'(1);
    assign sp_dn = sp - W'(1);

    // Purpose: drive the stack address and write strobe for this cycle.
    always_comb begin
        addr = (op == OP_POP) ? sp_dn : sp;
        we   = advance && (op == OP_PUSH);
    end

    // Purpose: stack pointer register with wrap-around update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (advance) begin
            if (op == OP_PUSH)     sp <= sp_up;
            else if (op == OP_POP) sp <= sp_dn;
        end
    end
endmodule

// File: rtl/stack_flow_unit.sv
// Module: stack_flow_unit (top)
// Executes the stack and control-transfer instruction group. It drives the
// next pc, the stack memory port and the register writeback request.
// Assumes reg_val holds the register named by instr[3:0] in the same cycle,
// and that the register file, stack memory and status register are external.
module stack_flow_unit
    import sfu_pkg::*;
#(
    parameter int            W          = 16,
    parameter int            IW         = 4,
    parameter logic [7:0]    GROUP_CODE = 8'h0F,
    parameter logic [IW-1:0] LINK_REG   = 4'hF,
    parameter logic [W-1:0]  RESET_PC   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [W-1:0]  instr,
    input  logic [W-1:0]  reg_val,
    input  logic [W-1:0]  r15_val,
    input  logic [W-1:0]  status_in,
    input  logic [W-1:0]  stack_rdata,
    input  logic          iret_load,
    input  logic [W-1:0]  iret_addr,
    output logic [W-1:0]  pc,
    output logic [W-1:0]  sp,
    output logic [W-1:0]  stack_addr,
    output logic          stack_we,
    output logic [W-1:0]  stack_wdata,
    output logic          wb_en,
    output logic [IW-1:0] wb_idx,
    output logic [W-1:0]  wb_data,
    output logic          zero_we,
    output logic          zero_val
);
    sfu_op_e      op;
    logic         advance;
    logic [W-1:0] pc_inc;

    assign advance = !stall;

    sfu_decode #(.W(W), .GROUP_CODE(GROUP_CODE)) u_decode (
        .instr (instr),
        .op    (op)
    );

    sfu_pc_ctrl #(.W(W), .RESET_PC(RESET_PC)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .op        (op),
        .reg_val   (reg_val),
        .r15_val   (r15_val),
        .iret_load (iret_load),
        .iret_addr (iret_addr),
        .pc        (pc),
        .pc_inc    (pc_inc)
    );

    sfu_stack_ctrl #(.W(W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .op      (op),
        .sp      (sp),
        .addr    (stack_addr),
        .we      (stack_we)
    );

    assign stack_wdata = reg_val;

    // Purpose: form the register writeback and zero-flag update requests.
    always_comb begin
        wb_en    = 1'b0;
        wb_idx   = instr[IW-1:0];
        wb_data  = '0;
        zero_we  = 1'b0;
        zero_val = 1'b0;
        if (advance) begin
            unique case (op)
                OP_POP: begin
                    wb_en    = 1'b1;
                    wb_data  = stack_rdata;
                    zero_we  = 1'b1;
                    zero_val = (stack_rdata == '0);
                end
                OP_FSR: begin
                    wb_en   = 1'b1;
                    wb_data = status_in;
                end
                OP_CALL: begin
                    wb_en   = 1'b1;
                    wb_idx  = LINK_REG;
                    wb_data = pc_inc;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stack_flow_unit_checks.sv
// Module: stack_flow_unit_checks
// Assertion checker bound to stack_flow_unit. It observes ports only and
// assumes the default 16-bit word with the group code 0x0F.
module stack_flow_unit_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        stall,
    input logic [15:0] instr,
    input logic [15:0] pc,
    input logic [15:0] sp,
    input logic [15:0] stack_addr,
    input logic        stack_we,
    input logic        wb_en,
    input logic [3:0]  wb_idx,
    input logic [15:0] wb_data,
    input logic        zero_we
);
    // R2: a push advances sp by one at the next edge.
    a_r2_push_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
        stack_we |=> sp == $past(sp) + 16'd1);

    // R2: a push writes at the current sp.
    a_r2_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        stack_we |-> stack_addr == sp);

    // R3: a pop (zero-flag update) moves sp down by one.
    a_r3_pop_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
        zero_we |=> sp == $past(sp) - 16'd1);

    // R6: a CALL links pc+1 into register 15.
    a_r6_call_link: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && instr[15:4] == 12'h0FE) |-> (wb_en && wb_idx == 4'hF && wb_data == pc + 16'd1));

    // R10: a stall freezes pc and sp.
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc) && $stable(sp)));

    // R10: no strobes leave the block during a stall.
    a_r10_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !(stack_we || wb_en || zero_we));

    // R3: a stack write and a zero-flag update never coincide.
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stack_we, zero_we}));
endmodule

bind stack_flow_unit stack_flow_unit_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .instr      (instr),
    .pc         (pc),
    .sp         (sp),
    .stack_addr (stack_addr),
    .stack_we   (stack_we),
    .wb_en      (wb_en),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data),
    .zero_we    (zero_we)
);

// File: tb/tb_stack_flow_unit.sv
// Bench: sweeps every 16-bit instruction word against an arithmetic model,
// with periodic stalls and interrupt-return loads, plus reset and wrap cases.
module tb_stack_flow_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] reg_val = '0;
    logic [15:0] r15_val = '0;
    logic [15:0] status_in = '0;
    logic [15:0] stack_rdata = '0;
    logic        iret_load = 1'b0;
    logic [15:0] iret_addr = '0;
    logic [15:0] pc, sp, stack_addr, stack_wdata, wb_data;
    logic        stack_we, wb_en, zero_we, zero_val;
    logic [3:0]  wb_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] m_pc, m_sp, m_iret;

    always #10 clk = ~clk;

    stack_flow_unit dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
        .reg_val(reg_val), .r15_val(r15_val), .status_in(status_in),
        .stack_rdata(stack_rdata), .iret_load(iret_load), .iret_addr(iret_addr),
        .pc(pc), .sp(sp), .stack_addr(stack_addr), .stack_we(stack_we),
        .stack_wdata(stack_wdata), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .zero_we(zero_we), .zero_val(zero_val)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, then state.
    task automatic step(input logic [15:0] w, input logic st, input logic ld,
                        input logic [15:0] rv, input logic [15:0] r15,
                        input logic [15:0] stat, input logic [15:0] srd,
                        input logic [15:0] iaddr);
        logic [3:0]  sub;
        logic [3:0]  r;
        logic        grp;
        logic [15:0] e_pc, e_sp, e_addr, e_wbd;
        logic        e_we, e_wb, e_z;
        logic [3:0]  e_idx;
        string       req;
        @(negedge clk);
        instr = w; stall = st; iret_load = ld; reg_val = rv; r15_val = r15;
        status_in = stat; stack_rdata = srd; iret_addr = iaddr;
        grp = (w[15:8] == 8'h0F);
        sub = w[7:4];
        r   = w[3:0];
        e_pc = m_pc + 16'd1; e_sp = m_sp; e_addr = m_sp;
        e_we = 0; e_wb = 0; e_z = 0; e_idx = r; e_wbd = '0;
        req = "R9";
        if (grp && sub == 4'h0)               begin req = "R2"; e_we = 1; e_sp = m_sp + 16'd1; end
        else if (grp && sub == 4'h1)          begin req = "R3"; e_addr = m_sp - 16'd1; e_sp = m_sp - 16'd1;
                                                    e_wb = 1; e_wbd = srd; e_z = 1; end
        else if (grp && sub == 4'hC)          begin req = "R4"; e_wb = 1; e_wbd = stat; end
        else if (grp && sub == 4'hD)          begin req = "R5"; e_pc = rv; end
        else if (grp && sub == 4'hE)          begin req = "R6"; e_pc = rv; e_wb = 1; e_idx = 4'hF;
                                                    e_wbd = m_pc + 16'd1; end
        else if (w == 16'h0FFF)               begin req = "R7"; e_pc = r15; end
        else if (w == 16'h0FBF)               begin req = "R8"; e_pc = m_iret; end
        if (st) begin
            req = "R10"; e_pc = m_pc; e_sp = m_sp; e_we = 0; e_wb = 0; e_z = 0;
        end
        #1;
        check(req, "stack_we", 32'(stack_we), 32'(e_we));
        check(req, "wb_en", 32'(wb_en), 32'(e_wb));
        check(req, "zero_we", 32'(zero_we), 32'(e_z));
        if (e_we) begin
            check(req, "push addr", 32'(stack_addr), 32'(e_addr));
            check(req, "push data", 32'(stack_wdata), 32'(rv));
        end
        if (e_z) begin
            check(req, "pop addr", 32'(stack_addr), 32'(e_addr));
            check(req, "zero_val", 32'(zero_val), 32'(srd == 16'h0));
        end
        if (e_wb) begin
            check(req, "wb_idx", 32'(wb_idx), 32'(e_idx));
            check(req, "wb_data", 32'(wb_data), 32'(e_wbd));
        end
        @(posedge clk);
        #1;
        m_pc = e_pc; m_sp = e_sp;
        if (ld) m_iret = iaddr;
        check(req, "pc", 32'(pc), 32'(m_pc));
        check(req, "sp", 32'(sp), 32'(m_sp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr = '0; stall = 0; iret_load = 0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_pc = '0; m_sp = '0; m_iret = '0;
        // R1: reset state
        check("R1", "pc", 32'(pc), 32'h0);
        check("R1", "sp", 32'(sp), 32'h0);
        check("R1", "stack_we", 32'(stack_we), 32'h0);
        check("R1", "wb_en", 32'(wb_en), 32'h0);
        check("R1", "zero_we", 32'(zero_we), 32'h0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: the interrupt-return register also clears; RETI goes to 0.
        step(16'h0000, 0, 0, 16'h1111, 16'h2222, 16'h0, 16'h0, 16'h0);
        step(16'h0FBF, 0, 0, 16'h1111, 16'h2222, 16'h0, 16'h0, 16'h0);
        check("R1", "iret after reset", 32'(pc), 32'h0);
        // R11: a pop at sp=0 wraps to 0xFFFF; a push at 0xFFFF wraps to 0.
        step(16'h0F13, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0000, 16'h0);
        check("R11", "sp wrap down", 32'(sp), 32'hFFFF);
        step(16'h0F02, 0, 0, 16'hBEEF, 16'h0, 16'h0, 16'h0, 16'h0);
        check("R11", "sp wrap up", 32'(sp), 32'h0);
        // R8: a load in the same cycle as RETI is not yet visible.
        step(16'h0FBF, 0, 1, 16'h0, 16'h0, 16'h0, 16'h0, 16'h4321);
        step(16'h0FBF, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        check("R8", "loaded iret", 32'(pc), 32'h4321);
        // R7/R8 neighbours act as no-operations (R9).
        for (int k = 0; k < 16; k++) begin
            step({12'h0FF, 4'(k)}, 0, 0, 16'h0, 16'hA5A5, 16'h0, 16'h0, 16'h0);
            step({12'h0FB, 4'(k)}, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        end
        // Exhaustive sweep over every instruction word (R2-R10).
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] iv;
            iv = 16'(i);
            step(iv, (i % 7) == 3, (i % 13) == 5,
                 iv * 16'h9E37 ^ 16'h5A5A, iv * 16'h0101 + 16'h0033,
                 ~iv, ((i % 5) == 0) ? 16'h0 : iv * 16'd3, iv ^ 16'hC3C3);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule